// File: doc/BRIEF.md
# Video Line Sampling Pulse Generator

This block produces a single sampling strobe for a video processing chain. It follows the line structure of the incoming picture by counting horizontal sync leading edges within each frame. A frame starts at the leading edge of vertical sync. At that edge the output goes high for one line. It goes high for one more line when the running line number equals a programmable sampling line.

Both sync inputs arrive with their polarity already normalised, so they are active high. They may be asynchronous to the system clock. Each one passes through a synchroniser and an edge detector, so a sync level that stays high counts only once. The sampling line number is a plain input port. It is compared only at horizontal edges. The output comes from a register and changes only on a detected sync edge.

Top module: `line_sample_pulse`

## Requirements
- R1: While reset is asserted, and after it is released, the output is low and the line counter is zero. The first horizontal edge after reset therefore takes the counter to line 1.
- R2: A vertical sync leading edge clears the line counter to zero and drives the output high.
- R3: Each horizontal sync leading edge without a vertical edge advances the line counter by one. After that edge the output is high exactly when the new line number equals `sample_line_i`, using the value present at that edge.
- R4: The output changes only on a detected sync edge. After a horizontal edge it holds its level until the next horizontal or vertical edge, so each pulse lasts one line period.
- R5: With `sample_line_i` = 0, a frame carries a single one-line pulse, the one started by vertical sync. No later line produces a match.
- R6: When vertical and horizontal leading edges are detected in the same clock cycle, the vertical edge takes priority. The counter becomes zero and the output goes high.
- R7: The line counter saturates at 2^LINE_W−1 and does not wrap. A horizontal edge that arrives while the counter is saturated drives the output low. With `sample_line_i` = 255, exactly line 255 pulses, and all later lines stay low.
- R8: A sync input held high for several clock cycles counts as one leading edge. The output reacts on the (SYNC_STAGES+1)-th rising clock edge after the input is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_i | input | 1 | Horizontal sync, active high, may be asynchronous |
| vsync_i | input | 1 | Vertical sync, active high, may be asynchronous |
| sample_line_i | input | LINE_W | Line number that triggers the second pulse |
| sample_pulse_o | output | 1 | Registered sampling pulse |

## Verification
The vertical frame-start edge and the horizontal line-advance edge can be detected in the same clock cycle. In that case the clear-to-zero and the increment compete for the counter, and the frame pulse and the match pulse compete for the output. The bench raises both sync inputs in the same clock period, so both edges leave the synchronisers together. It then judges the result by the next horizontal edges: the following line must be line 1, and a sampling line of 2 must pulse on the second line after the collision.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int DEF_LINE_W      = 8;
  localparam int DEF_SYNC_STAGES = 2;
  localparam int DEF_RST_STAGES  = 2;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LINE  = 2'd1,
    EV_FRAME = 2'd2
  } sync_ev_e;
endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/slp_strobe_edge.sv
module slp_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES:0] chain;
  logic            last_q;
  logic            last_d;

  assign chain[0] = strobe_i;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_sync
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= chain[gi];
      end
      assign chain[gi+1] = stage_q;
    end
  endgenerate

  always_comb begin
    last_d = chain[STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= last_d;
  end

  assign rise_o = chain[STAGES] & ~last_q;

  // R8
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/slp_line_counter.sv
module slp_line_counter
  import slp_pkg::*;
#(
  parameter int LINE_W = DEF_LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_rise_i,
  input  logic              v_rise_i,
  output sync_ev_e          ev_o,
  output logic              adv_o,
  output logic [LINE_W-1:0] cnt_next_o
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] cnt_q;
  logic [LINE_W-1:0] cnt_d;
  logic              cnt_en;
  sync_ev_e          ev;

  always_comb begin
    ev = EV_NONE;
    if (v_rise_i)      ev = EV_FRAME;
    else if (h_rise_i) ev = EV_LINE;
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    adv_o  = 1'b0;
    unique case (ev)
      EV_FRAME: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      EV_LINE: begin
        if (cnt_q != CNT_MAX) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
          adv_o  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ev_o       = ev;
  assign cnt_next_o = cnt_d;

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_rise_i |=> cnt_q == '0);
  // R3
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rise_i && !v_rise_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !v_rise_i) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/slp_pulse_gen.sv
module slp_pulse_gen
  import slp_pkg::*;
#(
  parameter int LINE_W = DEF_LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sync_ev_e          ev_i,
  input  logic              adv_i,
  input  logic [LINE_W-1:0] cnt_next_i,
  input  logic [LINE_W-1:0] sample_line_i,
  output logic              pulse_o
);
  logic pulse_q;
  logic pulse_d;
  logic pulse_en;

  always_comb begin
    pulse_d  = pulse_q;
    pulse_en = 1'b0;
    unique case (ev_i)
      EV_FRAME: begin
        pulse_d  = 1'b1;
        pulse_en = 1'b1;
      end
      EV_LINE: begin
        pulse_d  = adv_i && (cnt_next_i == sample_line_i);
        pulse_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_q <= 1'b0;
    else if (pulse_en) pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

  // R2
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i == EV_FRAME |=> pulse_q);
  // R4
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i == EV_NONE |=> $stable(pulse_q));
  // R7
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_LINE && !adv_i) |=> !pulse_q);
endmodule

// File: rtl/line_sample_pulse.sv
module line_sample_pulse
  import slp_pkg::*;
#(
  parameter int LINE_W      = DEF_LINE_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int RST_STAGES  = DEF_RST_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [LINE_W-1:0] sample_line_i,
  output logic              sample_pulse_o
);
  logic              rst_int_n;
  logic              h_rise;
  logic              v_rise;
  sync_ev_e          ev;
  logic              adv;
  logic [LINE_W-1:0] cnt_next;

  slp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  slp_strobe_edge #(.STAGES(SYNC_STAGES)) u_h_edge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_i (hsync_i),
    .rise_o   (h_rise)
  );

  slp_strobe_edge #(.STAGES(SYNC_STAGES)) u_v_edge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_i (vsync_i),
    .rise_o   (v_rise)
  );

  slp_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .h_rise_i   (h_rise),
    .v_rise_i   (v_rise),
    .ev_o       (ev),
    .adv_o      (adv),
    .cnt_next_o (cnt_next)
  );

  slp_pulse_gen #(.LINE_W(LINE_W)) u_pulse (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .ev_i          (ev),
    .adv_i         (adv),
    .cnt_next_i    (cnt_next),
    .sample_line_i (sample_line_i),
    .pulse_o       (sample_pulse_o)
  );

  // R6
  collide_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (v_rise && h_rise) |=> sample_pulse_o);
  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_int_n |-> !sample_pulse_o);
endmodule

// File: tb/tb_line_sample_pulse.sv
`timescale 1ns/1ps
module tb_line_sample_pulse;
  localparam int LINE_W = 8;
  localparam int NV     = 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              hsync;
  logic              vsync;
  logic [LINE_W-1:0] sample_line;
  logic              pulse;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  line_sample_pulse #(.LINE_W(LINE_W)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .hsync_i        (hsync),
    .vsync_i        (vsync),
    .sample_line_i  (sample_line),
    .sample_pulse_o (pulse)
  );

  // {event[1:0] (bit0 = hsync, bit1 = vsync), sample line, expected pulse}
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 8'd3, 1'b0},  // R1 idle after reset
    {2'b10, 8'd3, 1'b1},  // R2 frame start
    {2'b01, 8'd3, 1'b0},  // R3 line 1
    {2'b01, 8'd3, 1'b0},  // R3 line 2
    {2'b01, 8'd3, 1'b1},  // R3 line 3 matches
    {2'b01, 8'd3, 1'b0},  // R4 line 4 ends pulse
    {2'b10, 8'd0, 1'b1},  // R5 frame start, sample 0
    {2'b01, 8'd0, 1'b0},  // R5 line 1
    {2'b01, 8'd0, 1'b0},  // R5 line 2
    {2'b10, 8'd1, 1'b1},  // R2 frame start
    {2'b01, 8'd1, 1'b1},  // R3 line 1 matches
    {2'b01, 8'd1, 1'b0},  // R4 line 2
    {2'b11, 8'd2, 1'b1},  // R6 both edges together
    {2'b01, 8'd2, 1'b0},  // R6 next is line 1
    {2'b01, 8'd2, 1'b1},  // R6 line 2 matches
    {2'b00, 8'd2, 1'b1},  // R4 held without edge
    {2'b01, 8'd2, 1'b0},  // R4 line 3
    {2'b10, 8'd5, 1'b1},  // R2
    {2'b01, 8'd5, 1'b0},  // R3 line 1
    {2'b01, 8'd2, 1'b1}   // R3 sample changed to 2, line 2 matches
  };

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_ev(input logic [1:0] ev, input logic [LINE_W-1:0] s, input int hold);
    @(negedge clk);
    sample_line = s;
    hsync = ev[0];
    vsync = ev[1];
    repeat (hold) @(negedge clk);
    hsync = 1'b0;
    vsync = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    rst_n = 1'b0;
    hsync = 1'b0;
    vsync = 1'b0;
    sample_line = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset", pulse, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", pulse, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_ev(VEC[i][10:9], VEC[i][8:1], 1);
      chk($sformatf("vector %0d", i), pulse, VEC[i][0]);
    end

    // R8: held hsync counts once
    do_ev(2'b10, 8'd2, 1);
    do_ev(2'b01, 8'd2, 4);
    chk("R8 held level is line 1", pulse, 1'b0);
    do_ev(2'b01, 8'd2, 1);
    chk("R8 next is line 2", pulse, 1'b1);

    // R8: latency of SYNC_STAGES+1 edges
    do_ev(2'b01, 8'd2, 1);
    @(negedge clk);
    hsync = 1'b1;
    sample_line = 8'd4;
    @(negedge clk);
    hsync = 1'b0;
    @(negedge clk);
    chk("R8 not yet after 2 edges", pulse, 1'b0);
    @(negedge clk);
    chk("R8 after 3 edges", pulse, 1'b1);
    repeat (4) @(negedge clk);

    // R7: saturation with sample line 255
    do_ev(2'b10, 8'd255, 1);
    bad = 0;
    for (int k = 1; k <= 254; k++) begin
      do_ev(2'b01, 8'd255, 1);
      if (pulse !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R7 lines 1-254 high: got %0d expected 0", bad);
    end
    do_ev(2'b01, 8'd255, 1);
    chk("R7 line 255 pulses", pulse, 1'b1);
    do_ev(2'b01, 8'd255, 1);
    chk("R7 saturated line low", pulse, 1'b0);
    do_ev(2'b01, 8'd255, 1);
    chk("R7 still low", pulse, 1'b0);
    do_ev(2'b01, 8'd0, 1);
    chk("R5 no wrap to zero", pulse, 1'b0);

    // R1: reset in the middle of a pulse
    do_ev(2'b10, 8'd1, 1);
    chk("R2 before reset", pulse, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", pulse, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_ev(2'b01, 8'd1, 1);
    chk("R1 counter was zero", pulse, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule